// File: doc/BRIEF.md
# Eight-Channel DMA Register File and Transfer Sequencer

This block holds the programming state of eight DMA channels and paces their transfers. Software reaches every channel through one 32-bit register port. Each channel owns a 32-byte window that holds four registers: a mode word, a control word, a running address and a remaining byte count. Software loads a channel, sets its enable bit, and then polls the count or waits for the interrupt.

Peripheral devices raise a per-channel request. The block grants one channel at a time with a per-channel acknowledge. It holds that grant until the memory side reports that the transfer has finished, either cleanly or with an error. A clean finish moves the address forward and the count down by the channel's transfer width. When the count reaches zero, or when a transfer fails, the channel stops and raises a sticky flag. Software clears a flag by writing a one to it. The interrupt line is high while any channel has both a raised flag and its interrupt enable set.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every register of every channel reads zero, no acknowledge is driven and the interrupt is low.
- R2: Register address = channel×32 + offset. Offset 0x00 is mode, 0x08 is control, 0x10 is address and 0x18 is count; address bits 2:0 are ignored. Mode bits are: 2:0 access time, 4:3 width, 5 interrupt enable. Control bit 0 is enable and bit 1 is direction (1 = toward memory). All of these read back as written. Read data appears on the cycle after the read strobe.
- R3: Control bits 8 (terminal count), 9 (memory error) and 10 (address error) are write-one-to-clear. Writing 0 to a flag leaves it unchanged, and no register write can set a flag.
- R4: A channel is eligible when its request is high, its enable bit is set and its count is non-zero. When no transfer is in progress, the acknowledge goes to the lowest-numbered eligible channel on the clock edge after eligibility. A channel whose count is zero is never acknowledged.
- R5: A transfer that completes cleanly adds the width in bytes to the address and subtracts it from the count. Width code 01 means 2 bytes; every other code means 1 byte. The count never goes below zero.
- R6: When a clean completion brings the count to zero, the terminal-count flag is set and the enable bit is cleared. The direction bit is kept.
- R7: A completion with the memory-error input set raises bit 9, and one with the address-error input set raises bit 10. In either case the enable bit is cleared and the address and count are left unchanged.
- R8: The interrupt output is high exactly while some channel has its interrupt-enable bit and at least one of its three flags set.
- R9: Clearing the enable bit while a transfer is being acknowledged keeps the acknowledge up until that transfer completes. The completion still updates the counters, and no further acknowledge follows.
- R10: At most one acknowledge is high at any time. It stays stable until the completion input is seen and is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 8 | Byte address: channel in 7:5, register in 4:3 |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid the cycle after the read strobe |
| devReq | input | 8 | Per-channel device request |
| devAck | output | 8 | Per-channel acknowledge, at most one high |
| memDone | input | 1 | Completion of the acknowledged transfer |
| memErr | input | 1 | Memory error on the completing transfer |
| addrErr | input | 1 | Address error on the completing transfer |
| irq | output | 1 | Interrupt request |

## Verification
An acknowledge is due one clock edge after a request meets an idle, enabled channel with a non-zero count. Its release, together with the counter and flag updates, lands on the edge that samples the completion input. The interrupt follows the flags in that same cycle, and read data is due one edge after the read strobe.

The bench drives every input on the falling edge and checks acknowledge and interrupt at the next falling edge. Register reads go through a queue: the driver task pushes the expected value when it issues the read, and a monitor pops and compares it on the falling edge after the capturing edge.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int NUM_CH  = 8;
  localparam int CH_W    = $clog2(NUM_CH);
  localparam int GRP_W   = 5;              // 32-byte register window per channel
  localparam int RADDR_W = CH_W + GRP_W;

  // control-word bit positions
  localparam int EN_BIT   = 0;
  localparam int DIR_BIT  = 1;
  localparam int TC_BIT   = 8;
  localparam int MERR_BIT = 9;
  localparam int AERR_BIT = 10;

  localparam int MODE_W = 6;

  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_CTL  = 2'd1,
    SEL_ADDR = 2'd2,
    SEL_CNT  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic            wrMode;
    logic            wrCtl;
    logic            wrAddr;
    logic            wrCnt;
    logic            rdEn;
    logic [CH_W-1:0] regCh;
    regSel_e         regSel;
    logic            done;
    logic [CH_W-1:0] doneCh;
    logic            memErr;
    logic            addrErr;
  } ctrlStrb_t;
endpackage

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [RADDR_W-1:0] regAddr,
  input  logic [NUM_CH-1:0]  devReq,
  input  logic [NUM_CH-1:0]  chanReady,
  input  logic               memDone,
  input  logic               memErr,
  input  logic               addrErr,
  output logic [NUM_CH-1:0]  devAck,
  output ctrlStrb_t          strb
);
  logic            busy;
  logic [CH_W-1:0] curCh;
  logic [NUM_CH-1:0] cand;
  logic [CH_W-1:0] pickCh;
  logic            anyCand;
  regSel_e         sel;

  assign sel  = regSel_e'(regAddr[GRP_W-1:GRP_W-2]);
  assign cand = devReq & chanReady;

  // fixed priority: lowest channel number wins
  always_comb begin
    pickCh  = '0;
    anyCand = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (cand[i]) begin
        pickCh  = CH_W'(i);
        anyCand = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      curCh <= '0;
    end else if (busy) begin
      if (memDone) busy <= 1'b0;
    end else if (anyCand) begin
      busy  <= 1'b1;
      curCh <= pickCh;
    end
  end

  always_comb begin
    devAck = '0;
    if (busy) devAck[curCh] = 1'b1;
  end

  always_comb begin
    strb.wrMode  = regWrEn && (sel == SEL_MODE);
    strb.wrCtl   = regWrEn && (sel == SEL_CTL);
    strb.wrAddr  = regWrEn && (sel == SEL_ADDR);
    strb.wrCnt   = regWrEn && (sel == SEL_CNT);
    strb.rdEn    = regRdEn;
    strb.regCh   = regAddr[RADDR_W-1:GRP_W];
    strb.regSel  = sel;
    strb.done    = busy && memDone;
    strb.doneCh  = curCh;
    strb.memErr  = memErr;
    strb.addrErr = addrErr;
  end
endmodule

// File: rtl/dma_chan_dp.sv
module dma_chan_dp
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [NUM_CH-1:0] chanReady,
  output logic              irq
);
  logic [MODE_W-1:0] modeV [NUM_CH];
  logic [2:0]        flagV [NUM_CH];
  logic [1:0]        ctlV  [NUM_CH];
  logic [ADDR_W-1:0] addrV [NUM_CH];
  logic [CNT_W-1:0]  cntV  [NUM_CH];
  logic [NUM_CH-1:0] intV;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [MODE_W-1:0] modeR;
    logic              enR;
    logic              dirR;
    logic [2:0]        flagR;   // {addr err, mem err, terminal count}
    logic [ADDR_W-1:0] addrR;
    logic [CNT_W-1:0]  cntR;
    logic              selW;
    logic              hit;
    logic              okStep;
    logic              errStep;
    logic [2:0]        wBytes;
    logic [CNT_W-1:0]  cntNext;
    logic [2:0]        clrMask;
    logic [2:0]        setMask;

    assign selW    = (strb.regCh == CH_W'(i));
    assign hit     = strb.done && (strb.doneCh == CH_W'(i));
    assign errStep = hit && (strb.memErr || strb.addrErr);
    assign okStep  = hit && !errStep;
    assign wBytes  = (modeR[4:3] == 2'b01) ? 3'd2 : 3'd1;
    assign cntNext = (cntR > CNT_W'(wBytes)) ? cntR - CNT_W'(wBytes) : '0;
    assign clrMask = (strb.wrCtl && selW) ? regWrData[AERR_BIT:TC_BIT] : 3'b000;
    assign setMask = {hit && strb.addrErr, hit && strb.memErr,
                      okStep && (cntNext == '0)};

    always_ff @(posedge clk) begin
      if (!rstN) begin
        modeR <= '0;
        enR   <= 1'b0;
        dirR  <= 1'b0;
        flagR <= '0;
        addrR <= '0;
        cntR  <= '0;
      end else begin
        if (strb.wrMode && selW) modeR <= regWrData[MODE_W-1:0];
        if (strb.wrCtl && selW) begin
          enR  <= regWrData[EN_BIT];
          dirR <= regWrData[DIR_BIT];
        end
        // a stopping completion overrides a same-cycle software write
        if (errStep || (okStep && cntNext == '0)) enR <= 1'b0;
        flagR <= (flagR & ~clrMask) | setMask;
        if (strb.wrAddr && selW) addrR <= regWrData[ADDR_W-1:0];
        else if (okStep)         addrR <= addrR + ADDR_W'(wBytes);
        if (strb.wrCnt && selW)  cntR <= regWrData[CNT_W-1:0];
        else if (okStep)         cntR <= cntNext;
      end
    end

    assign modeV[i]     = modeR;
    assign flagV[i]     = flagR;
    assign ctlV[i]      = {dirR, enR};
    assign addrV[i]     = addrR;
    assign cntV[i]      = cntR;
    assign chanReady[i] = enR && (cntR != '0);
    assign intV[i]      = modeR[5] && (flagR != 3'b000);
  end

  assign irq = |intV;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdData <= '0;
    end else if (strb.rdEn) begin
      unique case (strb.regSel)
        SEL_MODE: regRdData <= DATA_W'(modeV[strb.regCh]);
        SEL_CTL:  regRdData <= DATA_W'({flagV[strb.regCh], 6'b0, ctlV[strb.regCh]});
        SEL_ADDR: regRdData <= DATA_W'(addrV[strb.regCh]);
        SEL_CNT:  regRdData <= DATA_W'(cntV[strb.regCh]);
        default:  regRdData <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [RADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [NUM_CH-1:0]  devReq,
  output logic [NUM_CH-1:0]  devAck,
  input  logic               memDone,
  input  logic               memErr,
  input  logic               addrErr,
  output logic               irq
);
  ctrlStrb_t         strb;
  logic [NUM_CH-1:0] chanReady;

  dma_chan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .devReq(devReq), .chanReady(chanReady),
    .memDone(memDone), .memErr(memErr), .addrErr(addrErr),
    .devAck(devAck), .strb(strb)
  );

  dma_chan_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrData(regWrData),
    .regRdData(regRdData), .chanReady(chanReady), .irq(irq)
  );
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk
  import dma_chan_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] devReq,
  input logic [NUM_CH-1:0] devAck,
  input logic              memDone
);
  a_r10_single_ack: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(devAck));

  a_r4_ack_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    (devAck != '0 && $past(devAck) == '0) |-> (($past(devReq) & devAck) != '0));

  a_r10_ack_held: assert property (@(posedge clk) disable iff (!rstN)
    (devAck != '0 && !memDone) |=> (devAck == $past(devAck)));

  a_r10_ack_release: assert property (@(posedge clk) disable iff (!rstN)
    (devAck != '0 && memDone) |=> (devAck == '0));
endmodule

bind dma_chan_regs dma_chan_regs_chk u_chk (
  .clk(clk), .rstN(rstN), .devReq(devReq), .devAck(devAck), .memDone(memDone)
);

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [7:0]  devReq = '0;
  logic [7:0]  devAck;
  logic        memDone = 1'b0;
  logic        memErr = 1'b0;
  logic        addrErr = 1'b0;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  logic rdPend = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } rdItem_t;
  rdItem_t sbq[$];

  localparam int M = 0, C = 1, A = 2, N = 3;   // register selectors

  always #5 clk = ~clk;

  dma_chan_regs u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .devReq(devReq), .devAck(devAck), .memDone(memDone),
    .memErr(memErr), .addrErr(addrErr), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(int ch, int sel, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 8'(ch * 32 + sel * 8); regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(int ch, int sel, logic [31:0] exp, string tag);
    rdItem_t it;
    @(negedge clk);
    it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    regRdEn = 1'b1; regAddr = 8'(ch * 32 + sel * 8);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  // one request/acknowledge/completion round on a single channel
  task automatic xfer(int ch, bit me, bit ae, string tag);
    @(negedge clk);
    devReq[ch] = 1'b1;
    @(negedge clk);
    check({tag, " ack"}, 32'(devAck), 32'(8'(1 << ch)));
    memDone = 1'b1; memErr = me; addrErr = ae; devReq[ch] = 1'b0;
    @(negedge clk);
    memDone = 1'b0; memErr = 1'b0; addrErr = 1'b0;
    check("R10 ack released", 32'(devAck), 32'h0);
  endtask

  // monitor side of the read scoreboard
  always @(posedge clk) rdPend <= regRdEn;
  always @(negedge clk) begin
    if (rdPend) begin
      if (sbq.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL R2: unexpected read data actual %h expected none", regRdData);
      end else begin
        rdItem_t it;
        it = sbq.pop_front();
        check(it.tag, regRdData, it.exp);
      end
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state
    check("R1 ack", 32'(devAck), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    rd(0, C, 32'h0, "R1 ch0 ctl");
    rd(7, N, 32'h0, "R1 ch7 cnt");
    rd(4, M, 32'h0, "R1 ch4 mode");

    // channel 3: 16-bit, irq enabled, access time 5
    wr(3, M, 32'h0000_002D);
    wr(3, A, 32'h1234_5670);
    wr(3, N, 32'd6);
    wr(3, C, 32'h0000_0703);
    rd(3, M, 32'h2D, "R2 mode readback");
    rd(3, A, 32'h1234_5670, "R2 addr readback");
    rd(3, C, 32'h3, "R3 flags not settable by write");

    xfer(3, 0, 0, "R4 ch3");
    rd(3, A, 32'h1234_5672, "R5 addr +2");
    rd(3, N, 32'd4, "R5 count -2");
    xfer(3, 0, 0, "R4 ch3");
    xfer(3, 0, 0, "R4 ch3");
    rd(3, C, 32'h102, "R6 terminal count stops channel");
    rd(3, N, 32'd0, "R6 count zero");
    rd(3, A, 32'h1234_5676, "R5 final addr");
    check("R8 irq on terminal count", 32'(irq), 32'h1);

    // disabled, zero-count channel is never acknowledged
    @(negedge clk);
    devReq[3] = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 no ack on zero count", 32'(devAck), 32'h0);
    devReq[3] = 1'b0;

    wr(3, C, 32'h0000_0102);
    rd(3, C, 32'h002, "R3 write one clears flag");
    check("R8 irq cleared", 32'(irq), 32'h0);

    // priority: channels 2 and 5 request together, 8-bit, irq disabled
    wr(5, M, 32'h0); wr(5, A, 32'h100); wr(5, N, 32'd2); wr(5, C, 32'h1);
    wr(2, M, 32'h0); wr(2, A, 32'h40);  wr(2, N, 32'd1); wr(2, C, 32'h1);
    @(negedge clk);
    devReq = 8'b0010_0100;
    @(negedge clk);
    check("R4 lowest channel wins", 32'(devAck), 32'h04);
    memDone = 1'b1; devReq[2] = 1'b0;
    @(negedge clk);
    memDone = 1'b0;
    check("R10 ack low after completion", 32'(devAck), 32'h0);
    @(negedge clk);
    check("R4 next channel granted", 32'(devAck), 32'h20);
    memDone = 1'b1; devReq[5] = 1'b0;
    @(negedge clk);
    memDone = 1'b0;
    check("R10 ack low", 32'(devAck), 32'h0);
    check("R8 irq masked by mode", 32'(irq), 32'h0);
    rd(2, C, 32'h100, "R6 ch2 done");
    rd(5, A, 32'h101, "R5 addr +1 for 8-bit");
    rd(5, N, 32'd1, "R5 count -1");

    // error completions
    xfer(5, 1, 0, "R7 ch5 mem");
    rd(5, C, 32'h200, "R7 memory error flag");
    rd(5, A, 32'h101, "R7 addr unchanged");
    rd(5, N, 32'd1, "R7 count unchanged");
    wr(5, C, 32'h1);
    rd(5, C, 32'h201, "R3 writing zero keeps flag");
    xfer(5, 0, 1, "R7 ch5 addr");
    rd(5, C, 32'h600, "R7 address error flag");
    wr(5, M, 32'h20);
    check("R8 irq from error flag", 32'(irq), 32'h1);

    // disable while acknowledged
    wr(1, M, 32'h0); wr(1, A, 32'h0); wr(1, N, 32'd4); wr(1, C, 32'h1);
    @(negedge clk);
    devReq[1] = 1'b1;
    @(negedge clk);
    check("R9 ack before disable", 32'(devAck), 32'h02);
    regWrEn = 1'b1; regAddr = 8'(1 * 32 + C * 8); regWrData = 32'h0;
    @(negedge clk);
    regWrEn = 1'b0;
    check("R9 ack held after disable", 32'(devAck), 32'h02);
    memDone = 1'b1;
    @(negedge clk);
    memDone = 1'b0;
    check("R9 ack released", 32'(devAck), 32'h0);
    repeat (3) @(negedge clk);
    check("R9 no further ack", 32'(devAck), 32'h0);
    devReq[1] = 1'b0;
    rd(1, N, 32'd3, "R9 count advanced");
    rd(1, A, 32'h1, "R9 addr advanced");
    rd(1, C, 32'h0, "R9 channel stopped without flag");

    repeat (3) @(negedge clk);
    if (sbq.size() != 0) begin
      nChecks++; nFails++;
      $display("FAIL R2: actual %0d reads unanswered expected 0", sbq.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule